// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Vector Generator

This block joins two eight-line priority controllers, a primary and a secondary, into one sixteen-line interrupt source for a processor. Request lines 0 to 7 go to the primary and lines 8 to 15 go to the secondary. Each controller latches its requests, tracks which lines are in service, and picks the pending line with the best priority under a rotating priority offset. A pending request on the secondary is forwarded into the primary's line 2 as a short pulse. The primary's verdict drives one interrupt level towards the processor.

The processor answers the interrupt with a one-cycle acknowledge strobe. On that strobe the block resolves the winner, updates the in-service and request bits, and registers an 8-bit vector. The vector is the selected controller's base times eight plus the line number. When the primary's winner is line 2, the secondary is resolved and acknowledged in the same cycle. Line 7 of whichever controller answers stands in as a spurious entry when no genuine request exists.

Every controller has its own vector base and its own automatic end-of-interrupt and rotate options. Every line has its own trigger-mode bit. The block does no register programming: it takes all configuration as static inputs.

Top module: `pic_cascade`

## Requirements
- R1: While reset is asserted, and right after it, `intr` and `vec_valid` are 0, `vector` is 0, and no request, in-service bit or rotation offset is held. The rotation offset resets to 0.
- R2: A line whose `trig_level` bit is 0 is edge triggered. A 0-to-1 transition sets its request one clock later. The request stays set after the line falls, until an acknowledge selects that line and clears it.
- R3: A line whose `trig_level` bit is 1 is level triggered. Its request follows the line with one clock of delay. An acknowledge does not clear it.
- R4: Within a controller with rotation offset r, line (r+k) mod 8 has priority k, and 0 is the best. The best pending line is valid only if no line of equal or better priority is in service.
- R5: `intr` is 1 exactly when the primary controller holds a valid winner. It is re-evaluated every cycle from registered state, including the cycle after each acknowledge.
- R6: An acknowledge with automatic end-of-interrupt off puts the winning line in service. That line and all lines of worse priority then no longer raise `intr`, while a better line still does.
- R7: An acknowledge with automatic end-of-interrupt on puts no line in service. If the rotate option is also on, the rotation offset becomes (winner+1) mod 8.
- R8: An acknowledge of a primary line other than 2 yields `vector` = {`mst_base`, line[2:0]}. `vec_valid` is high for exactly the one cycle after each `ack`.
- R9: While the secondary holds a valid winner and no `ack` is given, primary line 2 is pulsed. Its request is set one clock later if `trig_level[2]` is 0, and cleared if it is 1. An acknowledge won by primary line 2 also acknowledges the secondary's winner and yields {`slv_base`, secondary line[2:0]}.
- R10: If primary line 2 wins but the secondary holds no valid winner, the vector is {`slv_base`, 3'd7} and no secondary state changes.
- R11: An acknowledge while the primary holds no valid winner yields {`mst_base`, 3'd7} and changes no state.
- R12: External request `req[2]` has no effect; primary line 2 is driven only by the cascade pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 16 | Request lines; [7:0] primary, [15:8] secondary |
| trig_level | input | 16 | Per-line trigger mode, 1 = level, 0 = edge |
| mst_base | input | 5 | Primary vector base (upper five vector bits) |
| slv_base | input | 5 | Secondary vector base (upper five vector bits) |
| mst_aeoi | input | 1 | Primary automatic end-of-interrupt |
| mst_rot_aeoi | input | 1 | Primary rotate on automatic end-of-interrupt |
| slv_aeoi | input | 1 | Secondary automatic end-of-interrupt |
| slv_rot_aeoi | input | 1 | Secondary rotate on automatic end-of-interrupt |
| ack | input | 1 | Acknowledge strobe, one cycle |
| intr | output | 1 | Interrupt level to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after `ack` |
| vector | output | 8 | Registered interrupt vector |

## Verification
The hardest situation to reach is a spurious secondary answer. The primary must already hold its line 2 request, latched from an earlier cascade pulse, at the moment the secondary has lost its own request. The stimulus reaches it by raising a level-triggered secondary line long enough for the pulse to latch on an edge-mode primary line 2, then dropping the line before acknowledging. Random phases also keep the line states sticky and flip them rarely, so that edges, level drops, rotation and in-service blocking overlap with acknowledges. A reference model in the bench predicts every cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    VS_PRIMARY   = 2'd0,
    VS_SECONDARY = 2'd1,
    VS_SPUR_PRI  = 2'd2,
    VS_SPUR_SEC  = 2'd3
  } vec_src_e;
endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int LINES = 8,
  localparam int IDW = $clog2(LINES)
) (
  input  logic [LINES-1:0] bits_in,
  input  logic [IDW-1:0]   offset,
  output logic             found,
  output logic [IDW-1:0]   rank
);
  logic [LINES-1:0] rotated;

  for (genvar k = 0; k < LINES; k++) begin : g_rot
    logic [IDW-1:0] src;
    assign src = IDW'(k) + offset;
    assign rotated[k] = bits_in[src];
  end

  always_comb begin
    rank = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (rotated[k]) rank = IDW'(k);
    end
  end

  assign found = |bits_in;
endmodule

// File: rtl/pic_unit.sv
module pic_unit #(
  parameter int LINES = 8,
  localparam int IDW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  input  logic [LINES-1:0] lvl_mode,
  input  logic             aeoi,
  input  logic             rot_aeoi,
  input  logic             ack,
  input  logic [LINES-1:0] pulse,
  output logic             valid,
  output logic [IDW-1:0]   win_line
);
  logic [LINES-1:0] irr_q, irr_d, isr_q, isr_d, last_q;
  logic [IDW-1:0]   rot_q, rot_d;
  logic             req_found, svc_found;
  logic [IDW-1:0]   req_rank, svc_rank;

  pic_prio #(.LINES(LINES)) u_req (
    .bits_in(irr_q), .offset(rot_q), .found(req_found), .rank(req_rank)
  );
  pic_prio #(.LINES(LINES)) u_svc (
    .bits_in(isr_q), .offset(rot_q), .found(svc_found), .rank(svc_rank)
  );

  assign valid    = req_found && (!svc_found || (req_rank < svc_rank));
  assign win_line = req_rank + rot_q;

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    rot_d = rot_q;
    if (ack && valid) begin
      if (!aeoi)         isr_d[win_line] = 1'b1;
      else if (rot_aeoi) rot_d = win_line + IDW'(1);
      if (!lvl_mode[win_line]) irr_d[win_line] = 1'b0;
    end
    for (int i = 0; i < LINES; i++) begin
      if (lvl_mode[i])                  irr_d[i] = line_in[i];
      else if (line_in[i] && !last_q[i]) irr_d[i] = 1'b1;
      if (pulse[i])                     irr_d[i] = !lvl_mode[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      last_q <= '0;
      isr_q  <= '0;
      rot_q  <= '0;
    end else begin
      irr_q  <= irr_d;
      last_q <= line_in;
      if (ack) begin
        isr_q <= isr_d;
        rot_q <= rot_d;
      end
    end
  end

  // R6: a non-automatic acknowledge leaves the winner in service
  p_isr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && valid && !aeoi) |=> isr_q[$past(win_line)]);

  // R7: automatic end-of-interrupt never touches in-service bits
  p_aeoi_isr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi) |=> $stable(isr_q));

  // R7: rotation offset moves past the automatically ended line
  p_aeoi_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && valid && aeoi && rot_aeoi) |=> (rot_q == $past(win_line) + IDW'(1)));

  // R3: a held level request is not cleared by its acknowledge
  p_level_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && valid && lvl_mode[win_line] && line_in[win_line] && !pulse[win_line])
    |=> irr_q[$past(win_line)]);

  for (genvar i = 0; i < LINES; i++) begin : g_hold
    // R2: an edge request holds until acknowledged
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode[i] && irr_q[i] && !pulse[i] && !(ack && valid && win_line == IDW'(i)))
      |=> irr_q[i]);
  end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade #(
  parameter int VEC_W = 8,
  parameter int LINES = 8,
  parameter int CASC  = 2,
  localparam int IDW    = $clog2(LINES),
  localparam int BASE_W = VEC_W - IDW,
  localparam int ALL    = 2 * LINES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ALL-1:0]    req,
  input  logic [ALL-1:0]    trig_level,
  input  logic [BASE_W-1:0] mst_base,
  input  logic [BASE_W-1:0] slv_base,
  input  logic              mst_aeoi,
  input  logic              mst_rot_aeoi,
  input  logic              slv_aeoi,
  input  logic              slv_rot_aeoi,
  input  logic              ack,
  output logic              intr,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vector
);
  import pic_pkg::*;

  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC;
  localparam logic [IDW-1:0]   SPUR     = IDW'(LINES - 1);

  logic             m_valid, s_valid, s_ack;
  logic [IDW-1:0]   m_line, s_line;
  logic [LINES-1:0] m_lines, m_pulse;
  vec_src_e         src;
  logic [VEC_W-1:0] vector_d;

  assign m_lines = req[LINES-1:0] & ~CASC_BIT;
  assign m_pulse = (s_valid && !ack) ? CASC_BIT : '0;
  assign s_ack   = ack && m_valid && (m_line == IDW'(CASC));

  pic_unit #(.LINES(LINES)) u_pri (
    .clk(clk), .rst_n(rst_n), .line_in(m_lines),
    .lvl_mode(trig_level[LINES-1:0]), .aeoi(mst_aeoi), .rot_aeoi(mst_rot_aeoi),
    .ack(ack), .pulse(m_pulse), .valid(m_valid), .win_line(m_line)
  );

  pic_unit #(.LINES(LINES)) u_sec (
    .clk(clk), .rst_n(rst_n), .line_in(req[ALL-1:LINES]),
    .lvl_mode(trig_level[ALL-1:LINES]), .aeoi(slv_aeoi), .rot_aeoi(slv_rot_aeoi),
    .ack(s_ack), .pulse('0), .valid(s_valid), .win_line(s_line)
  );

  always_comb begin
    if (!m_valid)                    src = VS_SPUR_PRI;
    else if (m_line != IDW'(CASC))   src = VS_PRIMARY;
    else if (s_valid)                src = VS_SECONDARY;
    else                             src = VS_SPUR_SEC;
    case (src)
      VS_PRIMARY:   vector_d = {mst_base, m_line};
      VS_SECONDARY: vector_d = {slv_base, s_line};
      VS_SPUR_SEC:  vector_d = {slv_base, SPUR};
      default:      vector_d = {mst_base, SPUR};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vector    <= '0;
    end else begin
      vec_valid <= ack;
      if (ack) vector <= vector_d;
    end
  end

  assign intr = m_valid;

  // R8: one valid pulse per acknowledge
  p_vec_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);
  p_vec_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  // R11: acknowledge with nothing pending returns the primary spurious entry
  p_spur_pri_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !m_valid) |=> (vector == {$past(mst_base), SPUR}));

  // R10: cascade with an empty secondary returns the secondary spurious entry
  p_spur_sec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && m_valid && m_line == IDW'(CASC) && !s_valid)
    |=> (vector == {$past(slv_base), SPUR}));
endmodule

// File: tb/pic_cascade_test.sv
module pic_cascade_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req, trig_level;
  logic [4:0]  mst_base, slv_base;
  logic        mst_aeoi, mst_rot_aeoi, slv_aeoi, slv_rot_aeoi, ack;
  logic        intr, vec_valid;
  logic [7:0]  vector;

  pic_cascade uut (
    .clk(clk), .rst_n(rst_n), .req(req), .trig_level(trig_level),
    .mst_base(mst_base), .slv_base(slv_base), .mst_aeoi(mst_aeoi),
    .mst_rot_aeoi(mst_rot_aeoi), .slv_aeoi(slv_aeoi), .slv_rot_aeoi(slv_rot_aeoi),
    .ack(ack), .intr(intr), .vec_valid(vec_valid), .vector(vector)
  );

  always #5 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  bit [7:0] b_irr [2];
  bit [7:0] b_isr [2];
  bit [7:0] b_last [2];
  bit [2:0] b_rot [2];
  bit       exp_vv;
  bit [7:0] exp_vec;
  string    exp_kind;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic void resolve(input int u, output bit v, output bit [2:0] ln);
    bit fr = 0, fs = 0;
    int pr = 8, ps = 8;
    for (int k = 0; k < 8; k++) begin
      int idx = (k + int'(b_rot[u])) % 8;
      if (!fr && b_irr[u][idx]) begin fr = 1; pr = k; end
      if (!fs && b_isr[u][idx]) begin fs = 1; ps = k; end
    end
    v  = fr && (pr < ps);
    ln = 3'((pr + int'(b_rot[u])) % 8);
  endfunction

  function automatic void do_ack(input int u, input bit [2:0] ln);
    bit ae = (u == 0) ? mst_aeoi : slv_aeoi;
    bit ro = (u == 0) ? mst_rot_aeoi : slv_rot_aeoi;
    if (!ae) b_isr[u][ln] = 1'b1;
    else if (ro) b_rot[u] = ln + 3'd1;
    if (!trig_level[u*8 + int'(ln)]) b_irr[u][ln] = 1'b0;
  endfunction

  function automatic void apply_lines(input int u, input bit [7:0] l);
    for (int i = 0; i < 8; i++) begin
      if (trig_level[u*8 + i]) b_irr[u][i] = l[i];
      else if (l[i] && !b_last[u][i]) b_irr[u][i] = 1'b1;
    end
    b_last[u] = l;
  endfunction

  function automatic void model_step(input bit a, input bit [15:0] r);
    bit mv, sv;
    bit [2:0] ml, sl;
    resolve(0, mv, ml);
    resolve(1, sv, sl);
    exp_vv = a;
    if (a) begin
      if (!mv) begin
        exp_vec = {mst_base, 3'd7}; exp_kind = "R11";
      end else if (ml == 3'd2) begin
        if (sv) begin
          exp_vec = {slv_base, sl}; exp_kind = "R9"; do_ack(1, sl);
        end else begin
          exp_vec = {slv_base, 3'd7}; exp_kind = "R10";
        end
        do_ack(0, ml);
      end else begin
        exp_vec = {mst_base, ml}; exp_kind = "R8"; do_ack(0, ml);
      end
    end
    apply_lines(0, r[7:0] & 8'hFB);
    apply_lines(1, r[15:8]);
    if (sv && !a) b_irr[0][2] = !trig_level[2];
  endfunction

  task automatic check_outputs();
    bit v;
    bit [2:0] l;
    resolve(0, v, l);
    chk(intr == v, {"R5 ", cur_tag, " intr"}, intr, v);
    chk(vec_valid == exp_vv, "R8 vec_valid", vec_valid, exp_vv);
    if (exp_vv) chk(vector == exp_vec, {exp_kind, " vector"}, vector, exp_vec);
  endtask

  task automatic tick(input bit a, input bit [15:0] r);
    ack = a;
    req = r;
    model_step(a, r);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ack = 1'b0;
    req = '0;
    for (int u = 0; u < 2; u++) begin
      b_irr[u] = '0; b_isr[u] = '0; b_last[u] = '0; b_rot[u] = '0;
    end
    exp_vv = 0;
    exp_vec = '0;
    @(negedge clk);
    @(negedge clk);
    chk(intr == 1'b0, "R1 intr in reset", intr, 0);
    chk(vec_valid == 1'b0, "R1 vec_valid in reset", vec_valid, 0);
    chk(vector == 8'h00, "R1 vector in reset", vector, 0);
    rst_n = 1'b1;
  endtask

  task automatic set_cfg(input bit [15:0] tl, input bit [4:0] mb, input bit [4:0] sb,
                         input bit ma, input bit mr, input bit sa, input bit sr);
    trig_level = tl; mst_base = mb; slv_base = sb;
    mst_aeoi = ma; mst_rot_aeoi = mr; slv_aeoi = sa; slv_rot_aeoi = sr;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit [15:0] r;
    void'($urandom(32'd20240607));
    set_cfg(16'h0000, 5'h04, 5'h0E, 0, 0, 0, 0);
    do_reset();
    tick(0, 16'h0000);

    // R12: external line 2 toggling raises nothing; R11 spurious primary ack
    cur_tag = "R12";
    set_cfg(16'h0000, 5'h04, 5'h0E, 0, 0, 0, 0);
    do_reset();
    for (int i = 0; i < 6; i++) tick(0, (i % 2 == 0) ? 16'h0004 : 16'h0000);
    chk(intr == 1'b0, "R12 line 2 ignored", intr, 0);
    tick(1, 16'h0004);
    chk(vector == {5'h04, 3'd7}, "R11 spurious primary", vector, {5'h04, 3'd7});

    // R2: edge request held after line falls, cleared by ack
    cur_tag = "R2";
    do_reset();
    tick(0, 16'h0020);
    for (int i = 0; i < 3; i++) tick(0, 16'h0000);
    chk(intr == 1'b1, "R2 edge held", intr, 1);
    tick(1, 16'h0000);
    chk(vector == {5'h04, 3'd5}, "R8 line 5 vector", vector, {5'h04, 3'd5});
    tick(0, 16'h0000);
    chk(intr == 1'b0, "R2 cleared by ack", intr, 0);

    // R3: level request survives automatic acknowledges
    cur_tag = "R3";
    set_cfg(16'h0040, 5'h08, 5'h0E, 1, 0, 0, 0);
    do_reset();
    for (int i = 0; i < 2; i++) tick(0, 16'h0040);
    tick(1, 16'h0040);
    tick(1, 16'h0040);
    tick(0, 16'h0040);
    chk(intr == 1'b1, "R3 level survives ack", intr, 1);

    // R7: rotate on automatic end: lines 1,4 level -> wins 1, 4, 1
    cur_tag = "R7";
    set_cfg(16'h0012, 5'h10, 5'h0E, 1, 1, 0, 0);
    do_reset();
    tick(0, 16'h0012);
    tick(1, 16'h0012);
    chk(vector == {5'h10, 3'd1}, "R7 first winner", vector, {5'h10, 3'd1});
    tick(1, 16'h0012);
    chk(vector == {5'h10, 3'd4}, "R7 rotated winner", vector, {5'h10, 3'd4});
    tick(1, 16'h0012);
    chk(vector == {5'h10, 3'd1}, "R7 wrap winner", vector, {5'h10, 3'd1});

    // R6/R4: in-service line blocks worse lines but not better ones
    cur_tag = "R6";
    set_cfg(16'h0000, 5'h02, 5'h0E, 0, 0, 0, 0);
    do_reset();
    tick(0, 16'h0028);
    tick(1, 16'h0028);
    tick(0, 16'h0000);
    chk(intr == 1'b0, "R6 worse line blocked", intr, 0);
    cur_tag = "R4";
    tick(0, 16'h0002);
    tick(0, 16'h0000);
    chk(intr == 1'b1, "R4 better line preempts", intr, 1);

    // R9: cascade acknowledge of secondary line 12
    cur_tag = "R9";
    set_cfg(16'h0000, 5'h02, 5'h0E, 0, 0, 0, 0);
    do_reset();
    tick(0, 16'h1000);
    tick(0, 16'h1000);
    tick(0, 16'h0000);
    tick(1, 16'h0000);
    chk(vector == {5'h0E, 3'd4}, "R9 cascade vector", vector, {5'h0E, 3'd4});

    // R10: secondary level request dropped before the cascade ack
    cur_tag = "R10";
    set_cfg(16'h0800, 5'h02, 5'h0E, 0, 0, 0, 0);
    do_reset();
    for (int i = 0; i < 3; i++) tick(0, 16'h0800);
    tick(0, 16'h0000);
    tick(1, 16'h0000);
    chk(vector == {5'h0E, 3'd7}, "R10 spurious secondary", vector, {5'h0E, 3'd7});

    // random phases
    cur_tag = "R2/R3/R4/R6/R7/R9";
    for (int s = 0; s < 40; s++) begin
      set_cfg(16'($urandom), 5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom));
      do_reset();
      r = '0;
      for (int c = 0; c < 250; c++) begin
        r = r ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
        tick(($urandom % 4) == 0, r);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule